// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a three-wire link to a successive-approximation converter that has a chip-select input, a data-clock input and a serial data output. A one-cycle start request pulls chip select low and a data clock is made from the system clock. Its half period comes from a programmable divider, and that divider is clamped so that no clock phase is ever shorter than a set minimum. The converter uses the first five clock periods to sample its input and then sends one null bit, which should be low. After those six periods the result comes out most significant bit first. The converter changes the data line on the falling clock edge, so the reader samples it on the rising edge.

The reader takes a programmable number of result bits, as few as three, and then raises chip select. Stopping early cuts the conversion short and saves power. The captured bits are left-aligned into a 16-bit word with zeros below them, and the reader reports how many bits are valid. A null bit that reads high is flagged. An optional averaging stage adds up 1, 2, 4 or 8 consecutive results, which suits inputs near DC, and returns the sum shifted right by the log2 of the count.

Top module: `adc_host_reader`

## Requirements
- R1: After reset and while idle, chip select is high, the data clock is low, `valid_o` is low and `busy_o` is low.
- R2: A start accepted while idle pulls chip select low on the next clock edge. It stays low for exactly 2·h·(6+N) system cycles, in which the data clock, starting low, makes exactly 6+N rising edges.
- R3: The half period h equals `half_div_i` latched at start, raised to the minimum of 2 cycles when smaller. Every high phase and every low phase of the data clock lasts at least 2 cycles.
- R4: The data line is sampled at the rising clock edges. Rising edges 1 to 5 are discarded, edge 6 is the null bit, and edges 7 to 6+N give the result bits, most significant first.
- R5: N is `nbits_i` latched at start, clamped to the range 3 to 16. The result sits in the top N bits of `result_o` with zeros below, and `nvalid_o` equals N.
- R6: `null_err_o` is 1 together with a result when the null bit was read high, and 0 when it was read low.
- R7: With an averaging count of 1, `valid_o` is a single-cycle pulse in the cycle after chip select rises.
- R8: Chip select stays high for at least two cycles between reads, and a start request made while `busy_o` is high is ignored.
- R9: `avg_sel_i` = s (0 to 3) is latched at the first read of a group. `valid_o` is held low for the first 2^s−1 reads, and after the last read `result_o` is the sum of the 2^s left-aligned results shifted right by s. The accumulator cannot overflow, even when every result is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle read request |
| half_div_i | input | 8 | Data-clock half period in system cycles |
| nbits_i | input | 5 | Number of result bits to capture |
| avg_sel_i | input | 2 | Log2 of the averaging count |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Converter data clock |
| adc_sdo_i | input | 1 | Converter serial data |
| result_o | output | 16 | Left-aligned (averaged) result |
| nvalid_o | output | 5 | Number of valid upper bits in `result_o` |
| null_err_o | output | 1 | Null bit was read high |
| valid_o | output | 1 | Result strobe |
| busy_o | output | 1 | A read or its chip-select gap is in progress |

## Verification
Chip select goes low one edge after start and returns high 2·h·(6+N) cycles later, and the result strobe follows one further cycle after that. The bench samples at the falling system-clock edge. It counts the low cycles of chip select and the rising data-clock edges inside that window, and it checks the result, bit count and null flag in the very sample after chip select is seen high again. A converter model in the bench drives a fresh bit after each falling data-clock edge, so every bit has a full half period to settle before the reader takes it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   // Rising data-clock edges that precede the first result bit:
   // five acquisition periods plus the null bit.
   localparam int unsigned PRE_RISES = 6;

   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_RUN  = 2'd1,
      RD_GAP  = 2'd2
   } rd_state_e;
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             sclk,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (tick) begin
         cnt  <= '0;
         sclk <= ~sclk;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/adc_rd_frame.sv
module adc_rd_frame
   import adc_rd_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned NB_W     = 5,
   parameter int unsigned MIN_HALF = 2,
   parameter int unsigned MIN_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DIV_W-1:0]  half_div,
   input  logic [NB_W-1:0]   nbits,
   input  logic              sdo,
   input  logic              sclk,
   input  logic              tick,
   output logic              run,
   output logic [DIV_W-1:0]  half_q,
   output logic              cs_n,
   output logic              busy,
   output logic              raw_valid,
   output logic [DATA_W-1:0] raw_data,
   output logic [NB_W-1:0]   raw_nb,
   output logic              raw_nerr
);
   localparam int unsigned RW = $clog2(PRE_RISES + DATA_W + 1);

   rd_state_e         state;
   logic [RW-1:0]     rises;
   logic [RW-1:0]     rise_nxt;
   logic [NB_W-1:0]   nb_q;
   logic [DATA_W-1:0] shreg;
   logic [DIV_W-1:0]  gap_cnt;
   logic              null_q;
   logic              rise_ev, fall_ev, last_fall;
   logic [DIV_W-1:0]  half_lim;
   logic [NB_W-1:0]   nb_lim;

   assign run       = (state == RD_RUN);
   assign busy      = (state != RD_IDLE);
   assign rise_ev   = tick & ~sclk;
   assign fall_ev   = tick & sclk;
   assign rise_nxt  = rises + 1'b1;
   assign last_fall = fall_ev && (rises == RW'(PRE_RISES) + RW'(nb_q));

   always_comb begin
      half_lim = (half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div;
      if (nbits < NB_W'(MIN_BITS))    nb_lim = NB_W'(MIN_BITS);
      else if (nbits > NB_W'(DATA_W)) nb_lim = NB_W'(DATA_W);
      else                            nb_lim = nbits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RD_IDLE;
         cs_n      <= 1'b1;
         rises     <= '0;
         nb_q      <= NB_W'(MIN_BITS);
         half_q    <= DIV_W'(MIN_HALF);
         shreg     <= '0;
         gap_cnt   <= '0;
         null_q    <= 1'b0;
         raw_valid <= 1'b0;
         raw_data  <= '0;
         raw_nb    <= '0;
         raw_nerr  <= 1'b0;
      end else begin
         raw_valid <= 1'b0;
         unique case (state)
            RD_IDLE: if (start) begin
               state  <= RD_RUN;
               cs_n   <= 1'b0;
               rises  <= '0;
               shreg  <= '0;
               null_q <= 1'b0;
               half_q <= half_lim;
               nb_q   <= nb_lim;
            end
            RD_RUN: begin
               if (rise_ev) begin
                  rises <= rise_nxt;
                  if (rise_nxt == RW'(PRE_RISES)) null_q <= sdo;
                  else if (rise_nxt > RW'(PRE_RISES)) shreg <= {shreg[DATA_W-2:0], sdo};
               end
               if (last_fall) begin
                  state     <= RD_GAP;
                  cs_n      <= 1'b1;
                  gap_cnt   <= '0;
                  raw_valid <= 1'b1;
                  raw_data  <= shreg << (NB_W'(DATA_W) - nb_q);
                  raw_nb    <= nb_q;
                  raw_nerr  <= null_q;
               end
            end
            RD_GAP: begin
               gap_cnt <= gap_cnt + 1'b1;
               if (gap_cnt == half_q - 1'b1) state <= RD_IDLE;
            end
            default: state <= RD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_rd_avg.sv
module adc_rd_avg #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NB_W   = 5,
   parameter int unsigned SEL_W  = 2,
   parameter bit          AVG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  avg_sel,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [NB_W-1:0]   in_nb,
   input  logic              in_nerr,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [NB_W-1:0]   out_nb,
   output logic              out_nerr
);
   localparam int unsigned MAX_SH = (1 << SEL_W) - 1;
   localparam int unsigned ACC_W  = DATA_W + MAX_SH;

   generate
      if (!AVG_EN) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_data  <= '0;
               out_nb    <= '0;
               out_nerr  <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_data <= in_data;
                  out_nb   <= in_nb;
                  out_nerr <= in_nerr;
               end
            end
         end
      end else begin : g_accum
         logic [ACC_W-1:0]  acc, sum, shifted;
         logic [MAX_SH-1:0] grp_cnt, grp_last;
         logic [SEL_W-1:0]  sel_q, cur_sel;
         logic              nerr_acc;

         assign cur_sel  = (grp_cnt == '0) ? avg_sel : sel_q;
         assign sum      = acc + ACC_W'(in_data);
         assign grp_last = MAX_SH'((1 << cur_sel) - 1);
         assign shifted  = sum >>> cur_sel;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc       <= '0;
               grp_cnt   <= '0;
               sel_q     <= '0;
               nerr_acc  <= 1'b0;
               out_valid <= 1'b0;
               out_data  <= '0;
               out_nb    <= '0;
               out_nerr  <= 1'b0;
            end else begin
               out_valid <= 1'b0;
               if (in_valid) begin
                  if (grp_cnt == grp_last) begin
                     out_valid <= 1'b1;
                     out_data  <= shifted[DATA_W-1:0];
                     out_nb    <= in_nb;
                     out_nerr  <= nerr_acc | in_nerr;
                     acc       <= '0;
                     grp_cnt   <= '0;
                     nerr_acc  <= 1'b0;
                  end else begin
                     acc      <= sum;
                     grp_cnt  <= grp_cnt + 1'b1;
                     sel_q    <= cur_sel;
                     nerr_acc <= nerr_acc | in_nerr;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/adc_host_reader.sv
module adc_host_reader
   import adc_rd_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned MIN_HALF = 2,
   parameter int unsigned MIN_BITS = 3,
   parameter int unsigned SEL_W    = 2,
   parameter bit          AVG_EN   = 1'b1,
   localparam int unsigned NB_W    = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DIV_W-1:0]  half_div_i,
   input  logic [NB_W-1:0]   nbits_i,
   input  logic [SEL_W-1:0]  avg_sel_i,
   output logic              adc_cs_n_o,
   output logic              adc_sclk_o,
   input  logic              adc_sdo_i,
   output logic [DATA_W-1:0] result_o,
   output logic [NB_W-1:0]   nvalid_o,
   output logic              null_err_o,
   output logic              valid_o,
   output logic              busy_o
);
   if (MIN_HALF < 1 || MIN_HALF >= (1 << DIV_W)) begin : g_bad_half
      $error("MIN_HALF must fit the divider and be at least 1");
   end
   if (MIN_BITS < 1 || MIN_BITS > DATA_W || DATA_W < 2) begin : g_bad_bits
      $error("MIN_BITS must lie within 1..DATA_W");
   end

   logic              run, tick, sclk;
   logic [DIV_W-1:0]  half_q;
   logic              raw_valid, raw_nerr;
   logic [DATA_W-1:0] raw_data;
   logic [NB_W-1:0]   raw_nb;

   adc_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .half(half_q), .sclk(sclk), .tick(tick)
   );

   adc_rd_frame #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .NB_W(NB_W),
      .MIN_HALF(MIN_HALF), .MIN_BITS(MIN_BITS)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .start(start_i), .half_div(half_div_i),
      .nbits(nbits_i), .sdo(adc_sdo_i), .sclk(sclk), .tick(tick),
      .run(run), .half_q(half_q), .cs_n(adc_cs_n_o), .busy(busy_o),
      .raw_valid(raw_valid), .raw_data(raw_data), .raw_nb(raw_nb), .raw_nerr(raw_nerr)
   );

   adc_rd_avg #(
      .DATA_W(DATA_W), .NB_W(NB_W), .SEL_W(SEL_W), .AVG_EN(AVG_EN)
   ) u_avg (
      .clk(clk), .rst_n(rst_n), .avg_sel(avg_sel_i),
      .in_valid(raw_valid), .in_data(raw_data), .in_nb(raw_nb), .in_nerr(raw_nerr),
      .out_valid(valid_o), .out_data(result_o), .out_nb(nvalid_o), .out_nerr(null_err_o)
   );

   assign adc_sclk_o = sclk;
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
   parameter int unsigned MIN_HALF = 2
) (
   input logic clk,
   input logic rst_n,
   input logic adc_cs_n_o,
   input logic adc_sclk_o,
   input logic valid_o,
   input logic busy_o
);
   logic [15:0] hi_cnt, lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         lo_cnt <= '0;
      end else begin
         hi_cnt <= adc_sclk_o ? hi_cnt + 1'b1 : '0;
         lo_cnt <= (!adc_sclk_o && !adc_cs_n_o) ? lo_cnt + 1'b1 : '0;
      end
   end

   a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> adc_cs_n_o);
   a_r2_clk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n_o |-> !adc_sclk_o);
   a_r3_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_sclk_o) |-> hi_cnt >= 16'(MIN_HALF));
   a_r3_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_sclk_o) |-> lo_cnt >= 16'(MIN_HALF));
   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n_o) |=> adc_cs_n_o);
endmodule

bind adc_host_reader adc_rd_chk #(.MIN_HALF(MIN_HALF)) u_chk (
   .clk(clk), .rst_n(rst_n), .adc_cs_n_o(adc_cs_n_o), .adc_sclk_o(adc_sclk_o),
   .valid_o(valid_o), .busy_o(busy_o)
);

// File: tb/tb_adc_host_reader.sv
module tb_adc_host_reader;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  half_div_i = 8'd2;
   logic [4:0]  nbits_i = 5'd16;
   logic [1:0]  avg_sel_i = 2'd0;
   logic        adc_cs_n_o, adc_sclk_o;
   logic        adc_sdo_i = 1'b0;
   logic [15:0] result_o;
   logic [4:0]  nvalid_o;
   logic        null_err_o, valid_o, busy_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] adc_code = '0;
   logic        adc_null = 1'b0;
   int          fcnt = 0;

   always #(CLK_P/2) clk = ~clk;

   adc_host_reader dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_div_i(half_div_i),
      .nbits_i(nbits_i), .avg_sel_i(avg_sel_i), .adc_cs_n_o(adc_cs_n_o),
      .adc_sclk_o(adc_sclk_o), .adc_sdo_i(adc_sdo_i), .result_o(result_o),
      .nvalid_o(nvalid_o), .null_err_o(null_err_o), .valid_o(valid_o), .busy_o(busy_o)
   );

   // Converter model: a new bit follows every falling data-clock edge.
   always @(negedge adc_sclk_o) begin
      if (!adc_cs_n_o) begin
         fcnt = fcnt + 1;
         if (fcnt == 5) adc_sdo_i = adc_null;
         else if (fcnt >= 6 && fcnt <= 21) adc_sdo_i = adc_code[21 - fcnt];
         else adc_sdo_i = 1'b0;
      end
   end

   function automatic int clamp_n(int n);
      return (n < 3) ? 3 : ((n > 16) ? 16 : n);
   endfunction
   function automatic int clamp_h(int h);
      return (h < 2) ? 2 : h;
   endfunction
   function automatic int align(int code, int n);
      return ((code >> (16 - n)) << (16 - n)) & 32'hFFFF;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // One read; exp_valid/exp_data describe the strobe due after it.
   task automatic do_read(int code, int nreq, int div, int sel, bit nul,
                          bit exp_valid, int exp_data, bit exp_nerr, bit poke);
      int lowcnt = 0, rises = 0, guard = 0, n, h;
      logic prev_sclk = 1'b0;
      bit seen_low = 0;
      n = clamp_n(nreq);
      h = clamp_h(div);
      adc_code = code[15:0];
      adc_null = nul;
      fcnt = 0;
      adc_sdo_i = 1'b0;
      @(negedge clk);
      start_i = 1'b1; half_div_i = div[7:0]; nbits_i = nreq[4:0]; avg_sel_i = sel[1:0];
      @(negedge clk);
      start_i = 1'b0;
      forever begin
         if (!adc_cs_n_o) begin
            seen_low = 1;
            lowcnt++;
            if (adc_sclk_o && !prev_sclk) rises++;
         end else if (seen_low) break;
         prev_sclk = adc_sclk_o;
         if (poke && lowcnt == 10) begin
            start_i = 1'b1; half_div_i = 8'd1; nbits_i = 5'd3;
         end else start_i = 1'b0;
         guard++;
         if (guard > 4000) begin
            chk(0, "R2", "watchdog in read", guard, 0);
            return;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(lowcnt == 2*h*(6+n), "R2", "cs low cycles", lowcnt, 2*h*(6+n));
      chk(rises == 6+n, "R4", "rising edges in frame", rises, 6+n);
      @(negedge clk);
      chk(valid_o == exp_valid, exp_valid ? "R7" : "R9", "strobe", int'(valid_o), int'(exp_valid));
      if (exp_valid) begin
         chk(int'(result_o) == exp_data, "R5", "result", int'(result_o), exp_data);
         chk(int'(nvalid_o) == n, "R5", "bit count", int'(nvalid_o), n);
         chk(null_err_o == exp_nerr, "R6", "null flag", int'(null_err_o), int'(exp_nerr));
      end
      guard = 0;
      while (busy_o && guard < 1000) begin guard++; @(negedge clk); end
      if (poke) begin
         for (int i = 0; i < 40; i++) begin
            if (!adc_cs_n_o || valid_o) begin
               chk(0, "R8", "start while busy was taken", int'(adc_cs_n_o), 1);
               break;
            end
            @(negedge clk);
         end
         chk(adc_cs_n_o && !busy_o, "R8", "stays idle after ignored start", int'(adc_cs_n_o), 1);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      chk(0, "R1", "global watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int sum;
      int codes[8];
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      chk(adc_cs_n_o == 1'b1, "R1", "cs in reset", int'(adc_cs_n_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(adc_cs_n_o == 1'b1 && adc_sclk_o == 1'b0, "R1", "idle lines", int'(adc_sclk_o), 0);
      chk(valid_o == 1'b0 && busy_o == 1'b0, "R1", "idle strobe and busy", int'(busy_o), 0);

      // Directed corner cases
      do_read(16'hA5C3, 16, 2, 0, 0, 1, align(16'hA5C3, 16), 0, 0);   // R4 full read
      do_read(16'hFFFF, 3, 4, 0, 0, 1, align(16'hFFFF, 3), 0, 0);     // R5 short read
      do_read(16'h6000, 1, 3, 0, 0, 1, align(16'h6000, 3), 0, 0);     // R5 clamp up
      do_read(16'h1234, 20, 2, 0, 0, 1, align(16'h1234, 16), 0, 0);   // R5 clamp down
      do_read(16'h8001, 16, 0, 0, 0, 1, align(16'h8001, 16), 0, 0);   // R3 divider floor
      do_read(16'h0F0F, 8, 1, 0, 1, 1, align(16'h0F0F, 8), 1, 0);     // R6 null high
      do_read(16'h0F0F, 8, 2, 0, 0, 1, align(16'h0F0F, 8), 0, 1);     // R8 start ignored

      // R9: average of four
      codes[0] = 16'h1000; codes[1] = 16'h1003; codes[2] = 16'h0FFE; codes[3] = 16'h2001;
      sum = 0;
      for (int i = 0; i < 4; i++) begin
         sum += align(codes[i], 16);
         do_read(codes[i], 16, 2, 2, 0, i == 3, sum >> 2, 0, 0);
      end
      // R9: eight full-scale results must not wrap
      for (int i = 0; i < 8; i++)
         do_read(16'hFFFF, 16, 2, 3, 0, i == 7, 16'hFFFF, 0, 0);
      // R9: pair of short reads
      sum = align(16'hABCD, 12) + align(16'h5432, 12);
      do_read(16'hABCD, 12, 3, 1, 0, 0, 0, 0, 0);
      do_read(16'h5432, 12, 3, 1, 0, 1, sum >> 1, 0, 0);

      // Constrained random reads with averaging off
      for (int i = 0; i < 24; i++) begin
         int c = int'($urandom_range(0, 65535));
         int n = int'($urandom_range(3, 16));
         int d = int'($urandom_range(0, 5));
         do_read(c, n, d, 0, 0, 1, align(c, n), 0, 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule